// File: doc/BRIEF.md
# Prescaled PWM Event Counter Pair

This block is a two-stage timer. An input pulse stream, presented as a one-cycle strobe on `pulse_in`, is counted by a prescaler counter. When that counter equals the divider compare value, the counter restarts from zero and the stage emits a one-clock tick. The prescaler also has a mid-count compare that raises the second event flag after a chosen number of pulses. The prescaler can divide the stream by any ratio from 1 to 256.

Ticks from the prescaler advance a PWM counter. That counter has a period compare and a duty compare. A period match restarts the counter, raises the first event flag and returns the output to its period level. A later duty match moves the output to its duty level. A polarity bit selects which output level is high. Software programs five registers through a single write port. Each event flag holds until software acknowledges it, and each flag is gated by its own enable to form an interrupt request.

The output level is held by a two-state machine. The state `LVL_PERIOD` is entered on the transition `PERIOD_HIT`, which is a tick while the count equals the period value. The state `LVL_DUTY` is entered on the transition `DUTY_HIT`, which is a tick while the count equals the duty value and no period match occurs. In every other cycle the state holds.

Top module: `pwm_evt_pair`

## Requirements
- R1: A synchronous active-high `rst` clears both counters, both flags, the output (`pwm_out` = 0) and all five registers to zero.
- R2: In each cycle with `pulse_in` high, the prescaler count goes to 0 if it equals the divider value (address 0) and increments by one otherwise. Each such wrap emits one tick, so the stream is divided by divider+1: 0 gives divide by 1 and 255 gives divide by 256.
- R3: A cycle with `pulse_in` high while the prescaler count equals the mid value (address 1) sets `flag_evt2` at the next clock edge.
- R4: The PWM counter changes only one cycle after a tick. A tick while the count equals the period value (address 2) clears the count and sets `flag_evt1`. Any other tick increments the count.
- R5: With polarity 0, a period match drives `pwm_out` to 0. A tick at a count equal to the duty value (address 3) with no period match drives `pwm_out` to 1. Each change is visible in the cycle after the tick.
- R6: With polarity 1 (address 4, bit 0), `pwm_out` is the inverse of the polarity-0 waveform. A period match gives 1 and a duty match gives 0.
- R7: When the duty value is greater than or equal to the period value, `pwm_out` stays at its period-match level for the whole period.
- R8: Each flag stays set until `ack_evt1` or `ack_evt2` is high at a clock edge. A set event in the same cycle as the acknowledge wins, and the flag stays set.
- R9: `irq_evt1` equals `flag_evt1` AND enable bit 1 of address 4. `irq_evt2` equals `flag_evt2` AND enable bit 2 of address 4.
- R10: A write with `wr_en` high loads `wr_data` into the register at `wr_addr` (0 divider, 1 mid, 2 period, 3 duty, 4 control). The new value is used from the next cycle, including in the middle of a count. Addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | One-cycle strobe per input pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| ack_evt1 | input | 1 | Clears the period event flag |
| ack_evt2 | input | 1 | Clears the mid-count event flag |
| pwm_out | output | 1 | PWM waveform |
| flag_evt1 | output | 1 | Sticky period event flag |
| flag_evt2 | output | 1 | Sticky mid-count event flag |
| irq_evt1 | output | 1 | Enabled period interrupt |
| irq_evt2 | output | 1 | Enabled mid-count interrupt |

## Verification
A wrong prescaler count shows first at `flag_evt2`, within the current division cycle. It reaches `pwm_out` one prescaler wrap later, when a tick comes early or late. A wrong PWM count or output state moves the `pwm_out` edges and the moment `flag_evt1` is set, so it shows within one PWM period. A bench model that steps every clock compares all five outputs in every cycle, and so catches the first cycle in which any of them differs.

// File: rtl/pwmev_pkg.sv
package pwmev_pkg;
    localparam int ADDR_W   = 3;
    localparam int A_DIV    = 0;
    localparam int A_MID    = 1;
    localparam int A_PER    = 2;
    localparam int A_DUTY   = 3;
    localparam int A_CTRL   = 4;
    localparam int B_POL    = 0;
    localparam int B_IE1    = 1;
    localparam int B_IE2    = 2;
    localparam int N_EVT    = 2;

    typedef enum logic {
        LVL_PERIOD = 1'b0,
        LVL_DUTY   = 1'b1
    } pwm_lvl_e;
endpackage

// File: rtl/pwmev_regs.sv
module pwmev_regs
    import pwmev_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      div_q,
    output logic [W-1:0]      mid_q,
    output logic [W-1:0]      per_q,
    output logic [W-1:0]      duty_q,
    output logic              pol_q,
    output logic [N_EVT-1:0]  ie_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            mid_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
            pol_q  <= 1'b0;
            ie_q   <= '0;
        end else if (wr_en) begin
            unique case (int'(wr_addr))
                A_DIV:  div_q  <= wr_data;
                A_MID:  mid_q  <= wr_data;
                A_PER:  per_q  <= wr_data;
                A_DUTY: duty_q <= wr_data;
                A_CTRL: begin
                    pol_q <= wr_data[B_POL];
                    ie_q  <= {wr_data[B_IE2], wr_data[B_IE1]};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwmev_prescale.sv
module pwmev_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pulse_in,
    input  logic [W-1:0] div_q,
    input  logic [W-1:0] mid_q,
    output logic         tick,
    output logic         mid_hit
);
    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap    = pulse_in && (cnt_q == div_q);
    assign mid_hit = pulse_in && (cnt_q == mid_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= wrap;
            if (wrap)
                cnt_q <= '0;
            else if (pulse_in)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwmev_pwm.sv
module pwmev_pwm
    import pwmev_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] per_q,
    input  logic [W-1:0] duty_q,
    input  logic         pol_q,
    output logic [W-1:0] cnt_q,
    output logic         period_hit,
    output logic         pwm_out
);
    pwm_lvl_e state_q, state_d;
    logic     duty_hit;

    assign period_hit = tick && (cnt_q == per_q);
    assign duty_hit   = tick && !period_hit && (cnt_q == duty_q);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (period_hit)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_PERIOD: if (duty_hit)   state_d = LVL_DUTY;
            LVL_DUTY:   if (period_hit) state_d = LVL_PERIOD;
            default:                    state_d = LVL_PERIOD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LVL_PERIOD;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LVL_PERIOD: pwm_out = pol_q;
            LVL_DUTY:   pwm_out = !pol_q;
            default:    pwm_out = pol_q;
        endcase
    end
endmodule

// File: rtl/pwmev_flags.sv
module pwmev_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag[i] <= 1'b0;
            else if (set[i])
                flag[i] <= 1'b1;
            else if (ack[i])
                flag[i] <= 1'b0;
        end
        assign irq[i] = flag[i] && ie[i];
    end
endmodule

// File: rtl/pwm_evt_pair.sv
module pwm_evt_pair
    import pwmev_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              ack_evt1,
    input  logic              ack_evt2,
    output logic              pwm_out,
    output logic              flag_evt1,
    output logic              flag_evt2,
    output logic              irq_evt1,
    output logic              irq_evt2
);
    logic [W-1:0]     div_q, mid_q, per_q, duty_q, pwm_cnt;
    logic             pol_q, tick, mid_hit, period_hit;
    logic [N_EVT-1:0] ie_q, flags, irqs;

    pwmev_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .div_q(div_q), .mid_q(mid_q), .per_q(per_q), .duty_q(duty_q),
        .pol_q(pol_q), .ie_q(ie_q)
    );

    pwmev_prescale #(.W(W)) u_pre (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .div_q(div_q), .mid_q(mid_q),
        .tick(tick), .mid_hit(mid_hit)
    );

    pwmev_pwm #(.W(W)) u_pwm (
        .clk(clk), .rst(rst), .tick(tick), .per_q(per_q), .duty_q(duty_q),
        .pol_q(pol_q), .cnt_q(pwm_cnt), .period_hit(period_hit), .pwm_out(pwm_out)
    );

    pwmev_flags #(.N(N_EVT)) u_flags (
        .clk(clk), .rst(rst), .set({mid_hit, period_hit}), .ack({ack_evt2, ack_evt1}),
        .ie(ie_q), .flag(flags), .irq(irqs)
    );

    assign flag_evt1 = flags[0];
    assign flag_evt2 = flags[1];
    assign irq_evt1  = irqs[0];
    assign irq_evt2  = irqs[1];
endmodule

// File: rtl/pwm_evt_pair_chk.sv
module pwm_evt_pair_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         pulse_in,
    input logic         wr_en,
    input logic         tick,
    input logic [W-1:0] pwm_cnt,
    input logic [W-1:0] per_q,
    input logic         pwm_out,
    input logic         ack_evt2,
    input logic         flag_evt1,
    input logic         flag_evt2,
    input logic         irq_evt1,
    input logic         irq_evt2
);
    AST_TICK_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(pulse_in)); // R2
    AST_CNT_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pwm_cnt)); // R4
    AST_PERIOD_SETS_FLAG1: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_cnt == per_q) |=> (flag_evt1 && pwm_cnt == '0)); // R4
    AST_OUT_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(pwm_out)); // R5
    AST_FLAG2_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_evt2 && !ack_evt2) |=> flag_evt2); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!irq_evt1 || flag_evt1) && (!irq_evt2 || flag_evt2)); // R9
endmodule

bind pwm_evt_pair pwm_evt_pair_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .wr_en(wr_en), .tick(tick),
    .pwm_cnt(pwm_cnt), .per_q(per_q), .pwm_out(pwm_out), .ack_evt2(ack_evt2),
    .flag_evt1(flag_evt1), .flag_evt2(flag_evt2), .irq_evt1(irq_evt1), .irq_evt2(irq_evt2)
);

// File: tb/pwm_evt_pair_test.sv
module pwm_evt_pair_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack_evt1 = 1'b0;
    logic       ack_evt2 = 1'b0;
    logic       pwm_out, flag_evt1, flag_evt2, irq_evt1, irq_evt2;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    lfsr = 32'h1ACE;

    int m_pre, m_cnt, m_div, m_mid, m_per, m_duty;
    bit m_tick, m_lvl, m_f1, m_f2, m_pol, m_ie1, m_ie2, s1, s2, t;

    pwm_evt_pair uut (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ack_evt1(ack_evt1), .ack_evt2(ack_evt2), .pwm_out(pwm_out),
        .flag_evt1(flag_evt1), .flag_evt2(flag_evt2), .irq_evt1(irq_evt1), .irq_evt2(irq_evt2)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference, stepped once per clock
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_div = 0; m_mid = 0; m_per = 0; m_duty = 0;
            m_tick = 0; m_lvl = 0; m_f1 = 0; m_f2 = 0; m_pol = 0; m_ie1 = 0; m_ie2 = 0;
        end else begin
            s1 = m_tick && (m_cnt == m_per);
            s2 = pulse_in && (m_pre == m_mid);
            if (m_tick) begin
                if (s1) begin
                    m_cnt = 0;
                    m_lvl = 0;
                end else begin
                    if (m_cnt == m_duty) m_lvl = 1;
                    m_cnt = (m_cnt + 1) % 256;
                end
            end
            if (s1) m_f1 = 1; else if (ack_evt1) m_f1 = 0;
            if (s2) m_f2 = 1; else if (ack_evt2) m_f2 = 0;
            t = pulse_in && (m_pre == m_div);
            if (pulse_in) m_pre = t ? 0 : (m_pre + 1) % 256;
            m_tick = t;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_div = wr_data;
                    3'd1: m_mid = wr_data;
                    3'd2: m_per = wr_data;
                    3'd3: m_duty = wr_data;
                    3'd4: begin m_pol = wr_data[0]; m_ie1 = wr_data[1]; m_ie2 = wr_data[2]; end
                    default: ;
                endcase
            end
        end
        started = 1'b1;
    end

    task automatic chk(string what, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at cycle %0d", cur_req, what, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("pwm_out", int'(pwm_out), int'(m_lvl ^ m_pol));
            chk("flag_evt1", int'(flag_evt1), int'(m_f1));
            chk("flag_evt2", int'(flag_evt2), int'(m_f2));
            chk("irq_evt1", int'(irq_evt1), int'(m_f1 && m_ie1));
            chk("irq_evt2", int'(irq_evt2), int'(m_f2 && m_ie2));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[7:0];
        step();
        wr_en = 1'b0;
    endtask

    // mode 0: pulse every cycle, mode 1: pseudo-random pulses
    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            pulse_in = (mode == 0) ? 1'b1 : lfsr[0];
            step();
        end
        pulse_in = 1'b0;
    endtask

    task automatic ack(bit a1, bit a2);
        ack_evt1 = a1; ack_evt2 = a2;
        step();
        ack_evt1 = 1'b0; ack_evt2 = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("reset pwm_out", int'(pwm_out), 0);
        chk("reset flags", int'({flag_evt1, flag_evt2}), 0);
        step();
        cur_req = "R10";
        wr(0, 2); wr(1, 1); wr(2, 3); wr(3, 1); wr(4, 6); wr(5, 9); wr(7, 1);
        cur_req = "R2";
        run(60, 0);
        cur_req = "R3";
        run(60, 1);
        cur_req = "R8";
        ack(1, 1); run(3, 0); ack(1, 0); run(7, 0); ack(0, 1); run(20, 1);
        cur_req = "R9";
        wr(4, 2); run(30, 0); wr(4, 4); run(30, 0); wr(4, 0); ack(1, 1); run(20, 0);
        cur_req = "R6";
        wr(4, 7); run(60, 0); run(40, 1);
        cur_req = "R7";
        wr(3, 5); run(50, 0); wr(3, 3); run(50, 0);
        cur_req = "R5";
        wr(4, 6); wr(3, 0); run(50, 0); wr(3, 2); run(50, 1);
        cur_req = "R4";
        wr(2, 0); run(30, 0); wr(2, 6); run(60, 0);
        cur_req = "R10";
        run(5, 0); wr(2, 2); run(10, 0); wr(0, 1); run(10, 0); wr(2, 5); run(30, 1);
        cur_req = "R2";
        wr(0, 0); run(60, 1); wr(2, 3); wr(3, 1); wr(0, 255); wr(1, 200); run(1100, 0);
        cur_req = "R1";
        run(7, 0); rst = 1'b1; step(); rst = 1'b0;
        @(negedge clk);
        chk("reset mid-run pwm_out", int'(pwm_out), 0);
        chk("reset mid-run flags", int'({flag_evt1, flag_evt2}), 0);
        step();
        run(20, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        while (cycles < WDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL %s watchdog: got %0d expected %0d cycles", cur_req, cycles, WDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule